// File: doc/BRIEF.md
# Pin-Pair Flag Transfer Unit

This unit moves pin values between a 128-pin port and the two processor status flags, Z and C, in a single operation. Each operation names one pin by a 7-bit index and either reads pins into the flags (get) or writes the flags onto pins (set). When at least one flag write-enable is raised, the unit acts on the single named pin. When both write-enables are low, the unit works on the two-pin pair that holds the named pin instead of doing nothing.

In pair mode, one get operation turns all four line states of two adjacent pins into the two flags. Set mode is the inverse: it writes the two flags onto the pair. Naming the even pin or the odd pin of a pair decides which pin feeds Z and which feeds C. A caller can therefore swap the roles of two lines by picking the other index, without any extra steps. Z, C and the pin output and output-enable registers are all held inside the unit. They change only on a clock edge where an operation is strobed.

Top module: `pinpair_flags`

## Requirements
- R1: An active-high synchronous reset clears flag_z, flag_c, every bit of pin_out and every bit of pin_oe to 0.
- R2: Get with wr_z or wr_c high: on the clock edge that samples op_en, each enabled flag loads pins_in[pin_idx]. A flag whose enable is low keeps its value.
- R3: Set with wr_z or wr_c high: pin_out[pin_idx] takes flag_c if wr_c is high, otherwise flag_z. pin_oe[pin_idx] becomes 1.
- R4: Pair get with an even pin_idx (bit 0 = 0), where base is pin_idx with bit 0 cleared: flag_z loads pins_in[base+1] and flag_c loads pins_in[base].
- R5: Pair get with an odd pin_idx (bit 0 = 1): flag_z loads pins_in[base] and flag_c loads pins_in[base+1].
- R6: Pair set with an even pin_idx: pin_out[base+1] takes flag_z and pin_out[base] takes flag_c. Both enable bits become 1.
- R7: Pair set with an odd pin_idx: pin_out[base] takes flag_z and pin_out[base+1] takes flag_c. Both enable bits become 1.
- R8: A set operation leaves both flags unchanged. It also leaves every pin_out and pin_oe bit outside the addressed pin or pair unchanged.
- R9: A get operation leaves pin_out and pin_oe unchanged.
- R10: With op_en low, no flag, output bit or enable bit changes.
- R11: The lowest pair (indices 0 and 1) and the highest pair (indices 126 and 127) follow R4 to R7 with no effect outside the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_en | input | 1 | Performs one operation on this edge |
| op_set | input | 1 | 1 = set (flags to pins), 0 = get (pins to flags) |
| wr_z | input | 1 | Z write-enable; low together with wr_c selects pair mode |
| wr_c | input | 1 | C write-enable |
| pin_idx | input | 7 | Named pin index |
| pins_in | input | 128 | Pin input levels |
| flag_z | output | 1 | Z flag |
| flag_c | output | 1 | C flag |
| pin_out | output | 128 | Pin output value register |
| pin_oe | output | 128 | Pin output-enable register |

## Verification
The hardest case to reach is the orientation of pair set. Which flag lands on which pin only shows up when Z and C differ just before the set. Random stimulus often leaves them equal, or sets pins whose old output values already match, so a swapped orientation can go unseen. To prevent this, the stimulus runs pair gets on chosen pin patterns to load opposite flag values on purpose. It then runs pair sets at both the even and the odd index of the edge pairs, over an output register that already has bits set.

// File: rtl/pinpair_flags.sv
module pinpair_flags #(
  parameter int NPINS = 128,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_en,
  input  logic             op_set,
  input  logic             wr_z,
  input  logic             wr_c,
  input  logic [IDXW-1:0]  pin_idx,
  input  logic [NPINS-1:0] pins_in,
  output logic             flag_z,
  output logic             flag_c,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  logic            pair_mode, odd_sel;
  logic [IDXW-1:0] lo_idx, hi_idx;
  logic            z_next, c_next;
  logic [NPINS-1:0] set_mask, set_val;

  assign pair_mode = ~wr_z & ~wr_c;
  assign odd_sel   = pin_idx[0];
  assign lo_idx    = {pin_idx[IDXW-1:1], 1'b0};
  assign hi_idx    = {pin_idx[IDXW-1:1], 1'b1};

  always_comb begin
    if (pair_mode) begin
      z_next = odd_sel ? pins_in[lo_idx] : pins_in[hi_idx];
      c_next = odd_sel ? pins_in[hi_idx] : pins_in[lo_idx];
    end else begin
      z_next = wr_z ? pins_in[pin_idx] : flag_z;
      c_next = wr_c ? pins_in[pin_idx] : flag_c;
    end
  end

  always_comb begin
    set_mask = '0;
    set_val  = '0;
    if (pair_mode) begin
      set_mask[lo_idx] = 1'b1;
      set_mask[hi_idx] = 1'b1;
      set_val[lo_idx]  = odd_sel ? flag_z : flag_c;
      set_val[hi_idx]  = odd_sel ? flag_c : flag_z;
    end else begin
      set_mask[pin_idx] = 1'b1;
      set_val[pin_idx]  = wr_c ? flag_c : flag_z;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
      pin_out <= '0;
      pin_oe  <= '0;
    end else if (op_en) begin
      if (op_set) begin
        pin_out <= (pin_out & ~set_mask) | (set_val & set_mask);
        pin_oe  <= pin_oe | set_mask;
      end else begin
        flag_z <= z_next;
        flag_c <= c_next;
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> $stable(flag_z) && $stable(flag_c) && $stable(pin_out) && $stable(pin_oe)); // R10

  AST_GET_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
    op_en && !op_set |=> $stable(pin_out) && $stable(pin_oe)); // R9

  AST_SET_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    op_en && op_set |=> $stable(flag_z) && $stable(flag_c)); // R8

  AST_SET_OE_KEEP: assert property (@(posedge clk) disable iff (rst)
    op_en && op_set |=> ((pin_oe & $past(pin_oe)) == $past(pin_oe))); // R8

  AST_PAIR_SET_OE: assert property (@(posedge clk) disable iff (rst)
    op_en && op_set && !wr_z && !wr_c |=>
      pin_oe[$past(lo_idx)] && pin_oe[$past(hi_idx)]); // R6

  AST_PAIR_GET_QUIET: assert property (@(posedge clk) disable iff (rst)
    op_en && !op_set && !wr_z && !wr_c && !pins_in[lo_idx] && !pins_in[hi_idx]
      |=> !flag_z && !flag_c); // R4

  AST_SET_SINGLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    op_en && op_set && (wr_z || wr_c) |=>
      $countones(pin_oe ^ $past(pin_oe)) <= 1); // R3

endmodule

// File: tb/pinpair_flags_bench.sv
module pinpair_flags_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         op_en, op_set, wr_z, wr_c;
  logic [6:0]   pin_idx;
  logic [127:0] pins_in;
  logic         flag_z, flag_c;
  logic [127:0] pin_out, pin_oe;

  int vectors = 0;
  int misses  = 0;
  logic         m_z, m_c;
  logic [127:0] m_out, m_oe;

  always #10 clk = ~clk;

  pinpair_flags u_pinpair_flags (
    .clk(clk), .rst(rst), .op_en(op_en), .op_set(op_set), .wr_z(wr_z), .wr_c(wr_c),
    .pin_idx(pin_idx), .pins_in(pins_in), .flag_z(flag_z), .flag_c(flag_c),
    .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic string tag_of(logic en, logic st, logic wz, logic wc, logic [6:0] ix);
    if (!en) return "R10";
    if (wz || wc) return st ? "R3" : "R2";
    if (st) return ix[0] ? "R7" : "R6";
    return ix[0] ? "R5" : "R4";
  endfunction

  task automatic check_state(string tag);
    vectors++;
    if ({flag_z, flag_c} !== {m_z, m_c}) begin
      misses++;
      $display("FAIL %s flags: got z=%b c=%b expected z=%b c=%b", tag, flag_z, flag_c, m_z, m_c);
    end
    if (pin_out !== m_out || pin_oe !== m_oe) begin
      misses++;
      $display("FAIL %s pins: got out=%h oe=%h expected out=%h oe=%h", tag, pin_out, pin_oe, m_out, m_oe);
    end
  endtask

  task automatic apply(logic en, logic st, logic wz, logic wc, logic [6:0] ix,
                       logic [127:0] pv, string note);
    logic [6:0] lo, hi;
    string t, ft, pt;
    @(negedge clk);
    op_en = en; op_set = st; wr_z = wz; wr_c = wc; pin_idx = ix; pins_in = pv;
    lo = {ix[6:1], 1'b0};
    hi = {ix[6:1], 1'b1};
    if (en) begin
      if (!st) begin
        if (wz || wc) begin
          if (wz) m_z = pv[ix];
          if (wc) m_c = pv[ix];
        end else begin
          m_z = ix[0] ? pv[lo] : pv[hi];
          m_c = ix[0] ? pv[hi] : pv[lo];
        end
      end else begin
        if (wz || wc) begin
          m_out[ix] = wc ? m_c : m_z;
          m_oe[ix]  = 1'b1;
        end else begin
          m_out[lo] = ix[0] ? m_z : m_c;
          m_out[hi] = ix[0] ? m_c : m_z;
          m_oe[lo]  = 1'b1;
          m_oe[hi]  = 1'b1;
        end
      end
    end
    t = tag_of(en, st, wz, wc, ix);
    ft = (en && st) ? {t, "/R8"} : t;
    pt = (en && !st) ? {t, "/R9"} : ft;
    @(negedge clk);
    op_en = 1'b0;
    check_state({(st ? pt : ft), note});
  endtask

  initial begin
    #(20 * 150000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    rst = 1'b1; op_en = 1'b0; op_set = 1'b0; wr_z = 1'b0; wr_c = 1'b0;
    pin_idx = '0; pins_in = '0;
    m_z = 1'b0; m_c = 1'b0; m_out = '0; m_oe = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_state("R1 reset");

    // R11 edge pairs, Z and C forced opposite before each pair set
    apply(1, 0, 0, 0, 7'd0,   128'h1, " R11 low even get");
    apply(1, 1, 0, 0, 7'd0,   '0,     " R11 low even set");
    apply(1, 1, 0, 0, 7'd1,   '0,     " R11 low odd set");
    apply(1, 0, 0, 0, 7'd127, {2'b10, 126'h0}, " R11 high odd get");
    apply(1, 1, 0, 0, 7'd126, '0,     " R11 high even set");
    apply(1, 1, 0, 0, 7'd127, '0,     " R11 high odd set");
    apply(1, 0, 0, 0, 7'd126, {2'b01, 126'h0}, " R11 high even get");
    // all four pair states, even and odd index (R4 R5)
    for (int s = 0; s < 4; s++) begin
      apply(1, 0, 0, 0, 7'd42, 128'(s) << 42, " R4 state");
      apply(1, 0, 0, 0, 7'd43, 128'(s) << 42, " R5 state");
    end
    // single set priority when both enables high (R3)
    apply(1, 0, 1, 0, 7'd9, 128'h200, " R2 z only");
    apply(1, 0, 0, 1, 7'd9, 128'h0,   " R2 c only");
    apply(1, 1, 1, 1, 7'd20, '0, " R3 both enables");
    apply(1, 1, 1, 0, 7'd21, '0, " R3 z enable");
    // idle with busy inputs (R10)
    apply(0, 1, 0, 0, 7'd5, '1, " R10 idle");

    for (int n = 0; n < 3000; n++) begin
      logic [127:0] pv;
      logic [2:0]   ctl;
      pv  = {$urandom, $urandom, $urandom, $urandom};
      ctl = 3'($urandom);
      apply(($urandom % 8) != 0, ctl[0], ctl[1] & ctl[2], ctl[2] & ~ctl[1] & ctl[0],
            7'($urandom), pv, " random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule